// File: doc/BRIEF.md
# Bidirectional Pad Boundary-Scan Chain

This block is a serial test register that wraps a row of bidirectional I/O pads. Each pad has a pair of scan cells. One cell holds the value to drive and the other holds the driver enable. Every cell has a shift stage and an update latch. The test access controller sits outside the block. It supplies three strobes (capture, shift, update) and a two-bit test-mode code. Serial data enters on `tdi` and leaves on `tdo`.

In external-test mode the pads are driven from the update latches. On capture, each pad whose latched enable is off reads its pad value back into the chain, so the board wiring between chips can be checked for opens and stuck nets. Sample mode takes a snapshot of live pad and enable values while the core keeps driving the pins. Preload mode moves shifted data into the update latches of every pad at once, so external test can start from known values. In normal mode the core drives the pads directly.

Top module: `bidir_bscan_chain`

## Requirements
- R1: The chain is 2*NUM_PADS bits long. Chain bit 2i is the data cell of pad i and bit 2i+1 is its enable cell. With `shift_dr` high, each rising `tck` moves every bit one place toward `tdo`, and `tdi` enters the enable cell of the last pad. `tdo` always shows the data cell of pad 0.
- R2: The shift stage holds its contents on every edge where neither `shift_dr` nor `capture_dr` is high.
- R3: In external test (mode code 1), a capture loads the latched enable into each enable cell. It loads `pad_in[i]` into the data cell when that latched enable is 0, and the latched data value when it is 1.
- R4: In sample (mode code 2), a capture loads `pad_in[i]` into each data cell and `core_oe[i]` into each enable cell.
- R5: A capture in normal (mode code 0) or preload (mode code 3) leaves the shift stage unchanged.
- R6: `update_dr` in external test or preload copies the whole shift stage into the update latches on one edge. In sample or normal it is ignored, and the latches hold between updates.
- R7: In external test, `pad_out[i]` and `pad_oe[i]` show the update latches of pad i.
- R8: Outside external test, `pad_out` and `pad_oe` equal `core_out` and `core_oe` combinationally.
- R9: When `capture_dr` and `shift_dr` are high on the same edge, the capture takes effect and the shift does not.
- R10: When `update_dr` and `shift_dr` are high on the same edge, the latches receive the shift contents from before that edge, and the shift still happens.
- R11: `test_mode` is registered on each rising `tck` and takes effect from the following edge onward.
- R12: While `trst_n` is low, the mode is normal and the shift stage and update latches are clear, without waiting for a clock edge. After `trst_n` rises, the block stays in reset for two more rising `tck` edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| capture_dr | input | 1 | Capture strobe |
| shift_dr | input | 1 | Shift strobe |
| update_dr | input | 1 | Update strobe |
| test_mode | input | 2 | 0 normal, 1 external test, 2 sample, 3 preload |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| core_out | input | NUM_PADS | Core drive values |
| core_oe | input | NUM_PADS | Core driver enables |
| pad_in | input | NUM_PADS | Values read at the pads |
| pad_out | output | NUM_PADS | Values driven to the pads |
| pad_oe | output | NUM_PADS | Pad driver enables |

## Verification
Two strobe pairs can land on the same `tck` edge. Shift can coincide with update, and shift can coincide with capture. The bench first loads a known pattern in external test. It then raises shift and update together for one edge. The pad outputs must show the pattern from before that edge, and the next shift-out must show the pattern moved by one place with the `tdi` bit at the top. After that, shift and capture are raised together on one edge. The shifted-out word must match the external-test capture rule, with no trace of a shift.

// File: rtl/bscan_pkg.sv
package bscan_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL  = 2'd0,
    MODE_EXTEST  = 2'd1,
    MODE_SAMPLE  = 2'd2,
    MODE_PRELOAD = 2'd3
  } scan_mode_e;
endpackage

// File: rtl/bscan_rst_sync.sv
module bscan_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_n = stage2_q;
endmodule

// File: rtl/bscan_mode_reg.sv
module bscan_mode_reg
  import bscan_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_in,
  output scan_mode_e mode_q
);
  scan_mode_e mode_d;

  always_comb begin
    mode_d = scan_mode_e'(mode_in);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_NORMAL;
    else        mode_q <= mode_d;
  end

  // R11: mode follows the input with one edge of delay
  a_r11_mode_follow: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (mode_q == scan_mode_e'($past(mode_in))));
endmodule

// File: rtl/bscan_pad_cell.sv
module bscan_pad_cell
  import bscan_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  scan_mode_e mode,
  input  logic       capture_en,
  input  logic       shift_en,
  input  logic       update_en,
  input  logic       si,
  output logic       so,
  input  logic       core_out,
  input  logic       core_oe,
  input  logic       pad_in,
  output logic       pad_out,
  output logic       pad_oe
);
  logic dat_sh, oe_sh;
  logic dat_sh_d, oe_sh_d;
  logic upd_dat, upd_oe;
  logic upd_dat_d, upd_oe_d;
  logic cap_live, upd_live;

  assign cap_live = capture_en && ((mode == MODE_EXTEST) || (mode == MODE_SAMPLE));
  assign upd_live = update_en && ((mode == MODE_EXTEST) || (mode == MODE_PRELOAD));

  always_comb begin
    dat_sh_d = dat_sh;
    oe_sh_d  = oe_sh;
    if (capture_en) begin
      if (cap_live) begin
        if (mode == MODE_EXTEST) begin
          oe_sh_d  = upd_oe;
          dat_sh_d = upd_oe ? upd_dat : pad_in;
        end else begin
          oe_sh_d  = core_oe;
          dat_sh_d = pad_in;
        end
      end
    end else if (shift_en) begin
      oe_sh_d  = si;
      dat_sh_d = oe_sh;
    end
  end

  always_comb begin
    upd_dat_d = upd_dat;
    upd_oe_d  = upd_oe;
    if (upd_live) begin
      upd_dat_d = dat_sh;
      upd_oe_d  = oe_sh;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_sh <= 1'b0;
      oe_sh  <= 1'b0;
    end else if (capture_en || shift_en) begin
      dat_sh <= dat_sh_d;
      oe_sh  <= oe_sh_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_dat <= 1'b0;
      upd_oe  <= 1'b0;
    end else if (upd_live) begin
      upd_dat <= upd_dat_d;
      upd_oe  <= upd_oe_d;
    end
  end

  assign so      = dat_sh;
  assign pad_out = (mode == MODE_EXTEST) ? upd_dat : core_out;
  assign pad_oe  = (mode == MODE_EXTEST) ? upd_oe  : core_oe;

  // R1: one step along the pair per shift edge
  a_r1_chain_step: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !capture_en) |=> (dat_sh == $past(oe_sh)) && (oe_sh == $past(si)));
  // R2: shift stage idle without strobes
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && !capture_en) |=> $stable(dat_sh) && $stable(oe_sh));
  // R3: a driven pad captures its latched data value
  a_r3_driven_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_en && mode == MODE_EXTEST && upd_oe) |=> (dat_sh == $past(upd_dat)));
  // R5: preload capture does not disturb the shift stage
  a_r5_preload_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_en && mode == MODE_PRELOAD) |=> $stable(dat_sh) && $stable(oe_sh));
  // R6: latches hold without an update strobe
  a_r6_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !update_en |=> $stable(upd_dat) && $stable(upd_oe));
  // R6: sample mode ignores update
  a_r6_sample_no_update: assert property (@(posedge clk) disable iff (!rst_n)
    (update_en && mode == MODE_SAMPLE) |=> $stable(upd_dat) && $stable(upd_oe));
  // R10: update alongside shift takes pre-shift contents
  a_r10_update_pre_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (update_en && shift_en && mode == MODE_EXTEST) |=>
      (upd_dat == $past(dat_sh)) && (upd_oe == $past(oe_sh)));
endmodule

// File: rtl/bidir_bscan_chain.sv
module bidir_bscan_chain
  import bscan_pkg::*;
#(
  parameter int NUM_PADS = 4
) (
  input  logic                tck,
  input  logic                trst_n,
  input  logic                capture_dr,
  input  logic                shift_dr,
  input  logic                update_dr,
  input  logic [1:0]          test_mode,
  input  logic                tdi,
  output logic                tdo,
  input  logic [NUM_PADS-1:0] core_out,
  input  logic [NUM_PADS-1:0] core_oe,
  input  logic [NUM_PADS-1:0] pad_in,
  output logic [NUM_PADS-1:0] pad_out,
  output logic [NUM_PADS-1:0] pad_oe
);
  localparam int ChainLen = 2 * NUM_PADS;

  logic       rst_n;
  scan_mode_e mode_q;
  logic [NUM_PADS:0] link;

  bscan_rst_sync i_rst_sync (
    .clk    (tck),
    .arst_n (trst_n),
    .rst_n  (rst_n)
  );

  bscan_mode_reg i_mode_reg (
    .clk     (tck),
    .rst_n   (rst_n),
    .mode_in (test_mode),
    .mode_q  (mode_q)
  );

  assign link[NUM_PADS] = tdi;

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    bscan_pad_cell i_cell (
      .clk        (tck),
      .rst_n      (rst_n),
      .mode       (mode_q),
      .capture_en (capture_dr),
      .shift_en   (shift_dr),
      .update_en  (update_dr),
      .si         (link[p+1]),
      .so         (link[p]),
      .core_out   (core_out[p]),
      .core_oe    (core_oe[p]),
      .pad_in     (pad_in[p]),
      .pad_out    (pad_out[p]),
      .pad_oe     (pad_oe[p])
    );
  end

  assign tdo = link[0];

  // R12: during reset, pads are under core control
  a_r12_reset_core: assert property (@(posedge tck)
    !rst_n |-> (pad_out == core_out) && (pad_oe == core_oe) && !tdo);
  // R8: sample mode leaves the core in charge of the pins
  a_r8_sample_core: assert property (@(posedge tck) disable iff (!rst_n)
    (mode_q == MODE_SAMPLE) |-> (pad_out == core_out) && (pad_oe == core_oe));

  initial begin
    if (ChainLen < 2) $error("chain too short");
  end
endmodule

// File: tb/test_bidir_bscan_chain.sv
module test_bidir_bscan_chain;
  localparam int N = 4;
  localparam int L = 2 * N;

  logic tck = 1'b0;
  logic trst_n, capture_dr, shift_dr, update_dr, tdi;
  logic [1:0] test_mode;
  logic [N-1:0] core_out, core_oe, pad_in;
  logic tdo;
  logic [N-1:0] pad_out, pad_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 tck = ~tck;

  bidir_bscan_chain #(.NUM_PADS(N)) i_bidir_bscan_chain (
    .tck(tck), .trst_n(trst_n), .capture_dr(capture_dr), .shift_dr(shift_dr),
    .update_dr(update_dr), .test_mode(test_mode), .tdi(tdi), .tdo(tdo),
    .core_out(core_out), .core_oe(core_oe), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic chk(input string req, input logic [L-1:0] act, input logic [L-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge tck);
    #5;
  endtask

  task automatic shift_vec(input logic [L-1:0] v, output logic [L-1:0] old);
    shift_dr = 1'b1;
    for (int k = 0; k < L; k++) begin
      old[k] = tdo;
      tdi = v[k];
      step();
    end
    shift_dr = 1'b0;
  endtask

  task automatic pulse_capture();
    capture_dr = 1'b1; step(); capture_dr = 1'b0;
  endtask

  task automatic pulse_update();
    update_dr = 1'b1; step(); update_dr = 1'b0;
  endtask

  task automatic set_mode(input logic [1:0] m);
    test_mode = m; step();
  endtask

  function automatic logic [N-1:0] even_bits(input logic [L-1:0] v);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = v[2*i];
    return r;
  endfunction

  function automatic logic [N-1:0] odd_bits(input logic [L-1:0] v);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = v[2*i+1];
    return r;
  endfunction

  function automatic logic [L-1:0] exp_extest(input logic [N-1:0] d, input logic [N-1:0] oe,
                                              input logic [N-1:0] pin);
    logic [L-1:0] r;
    for (int i = 0; i < N; i++) begin
      r[2*i+1] = oe[i];
      r[2*i]   = oe[i] ? d[i] : pin[i];
    end
    return r;
  endfunction

  function automatic logic [L-1:0] exp_sample(input logic [N-1:0] pin, input logic [N-1:0] oe);
    logic [L-1:0] r;
    for (int i = 0; i < N; i++) begin
      r[2*i+1] = oe[i];
      r[2*i]   = pin[i];
    end
    return r;
  endfunction

  task automatic t_reset();
    trst_n = 1'b0; capture_dr = 0; shift_dr = 0; update_dr = 0; tdi = 0;
    test_mode = 2'd0; core_out = 4'b1001; core_oe = 4'b0110; pad_in = 4'b0000;
    #3;
    chk("R12 tdo in reset", L'(tdo), '0);
    chk("R12 pad_out in reset", L'(pad_out), L'(core_out));
    chk("R12 pad_oe in reset", L'(pad_oe), L'(core_oe));
    step(); trst_n = 1'b1; step(); step(); step();
  endtask

  task automatic t_chain();
    logic [L-1:0] old;
    shift_vec(8'hC3, old);
    chk("R12 shift stage clear after reset", old, '0);
    shift_vec(8'h5E, old);
    chk("R1 chain order", old, 8'hC3);
    step(); step(); step();
    shift_vec(8'h00, old);
    chk("R2 idle hold", old, 8'h5E);
  endtask

  task automatic t_extest();
    logic [L-1:0] old;
    set_mode(2'd1);
    shift_vec(8'h27, old);
    chk("R6 latch hold before update", L'({pad_oe, pad_out}), '0);
    pulse_update();
    chk("R7 pad_out from latch", L'(pad_out), L'(even_bits(8'h27)));
    chk("R7 pad_oe from latch", L'(pad_oe), L'(odd_bits(8'h27)));
    pad_in = 4'b1010;
    pulse_capture();
    shift_vec(8'h00, old);
    chk("R3 extest capture", old, exp_extest(even_bits(8'h27), odd_bits(8'h27), 4'b1010));
  endtask

  task automatic t_sample();
    logic [L-1:0] old;
    set_mode(2'd2);
    #1;
    chk("R8 sample pad_out", L'(pad_out), L'(core_out));
    chk("R8 sample pad_oe", L'(pad_oe), L'(core_oe));
    pad_in = 4'b0011;
    pulse_capture();
    shift_vec(8'hFF, old);
    chk("R4 sample capture", old, exp_sample(4'b0011, core_oe));
    pulse_update();
    set_mode(2'd1);
    chk("R6 sample update ignored", L'({pad_oe, pad_out}),
        L'({odd_bits(8'h27), even_bits(8'h27)}));
  endtask

  task automatic t_preload();
    logic [L-1:0] old;
    set_mode(2'd3);
    shift_vec(8'hD8, old);
    pad_in = 4'b1111;
    pulse_capture();
    pulse_update();
    chk("R8 preload pads on core", L'({pad_oe, pad_out}), L'({core_oe, core_out}));
    shift_vec(8'h00, old);
    chk("R5 preload capture ignored", old, 8'hD8);
    set_mode(2'd0);
    shift_vec(8'h6B, old);
    pulse_capture();
    shift_vec(8'h00, old);
    chk("R5 normal capture ignored", old, 8'h6B);
    set_mode(2'd1);
    chk("R6 preload update", L'({pad_oe, pad_out}), L'({odd_bits(8'hD8), even_bits(8'hD8)}));
  endtask

  task automatic t_overlap();
    logic [L-1:0] old;
    shift_vec(8'h5A, old);
    shift_dr = 1'b1; update_dr = 1'b1; tdi = 1'b1;
    step();
    shift_dr = 1'b0; update_dr = 1'b0;
    chk("R10 update takes pre-shift value", L'({pad_oe, pad_out}),
        L'({odd_bits(8'h5A), even_bits(8'h5A)}));
    shift_vec(8'h00, old);
    chk("R10 shift still happened", old, {1'b1, 7'h2D});
    pad_in = 4'b0110;
    shift_dr = 1'b1; capture_dr = 1'b1; tdi = 1'b0;
    step();
    shift_dr = 1'b0; capture_dr = 1'b0;
    shift_vec(8'h00, old);
    chk("R9 capture wins over shift", old,
        exp_extest(even_bits(8'h5A), odd_bits(8'h5A), 4'b0110));
  endtask

  task automatic t_mode_reset();
    logic [L-1:0] old;
    test_mode = 2'd0;
    #1;
    chk("R11 mode lag", L'(pad_oe), L'(odd_bits(8'h5A)));
    step();
    chk("R11 normal after edge", L'({pad_oe, pad_out}), L'({core_oe, core_out}));
    set_mode(2'd1);
    chk("R11 extest after edge", L'(pad_oe), L'(odd_bits(8'h5A)));
    shift_vec(8'hA5, old);
    trst_n = 1'b0;
    #1;
    chk("R12 async reset to core", L'({pad_oe, pad_out}), L'({core_oe, core_out}));
    step();
    trst_n = 1'b1;
    step(); step();
    chk("R12 held two edges", L'({pad_oe, pad_out}), L'({core_oe, core_out}));
    step();
    chk("R12 latches cleared", L'({pad_oe, pad_out}), '0);
    shift_vec(8'h00, old);
    chk("R12 shift cleared", old, '0);
  endtask

  initial begin
    t_reset();
    t_chain();
    t_extest();
    t_sample();
    t_preload();
    t_overlap();
    t_mode_reset();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule